// File: doc/BRIEF.md
# Per-Port Interface Clock Setup Sequencer

This block turns a small per-port configuration table into the ordered list of 32-bit register writes that a clock-generation unit needs. On a start pulse it visits the switch ports one at a time, in ascending order. For each port it reads the interface kind (MII, RMII, RGMII or SGMII), whether the port acts as MAC or PHY, and its link speed. It then issues the clock-control writes for that port over a valid/ready command port. Each command carries an address and a data word. The transport that later carries these writes, and the clock muxes and PLLs they program, sit outside the block.

The block computes every data word itself. Clock-select words carry a 5-bit source code, an always-set auto-block flag and a power-down bit. Divider words carry the divide factor. The PLL word is written twice, first parked in power-down and then released. Register addresses come from parameters: a base address, a per-kind span and a per-port stride. An absent-register mask marks registers that do not exist, and a write aimed at an absent register is dropped quietly. The block stops with an error flag and the port index when a port holds an unknown interface code, or an RGMII speed code that means nothing.

The state machine has four states. IDLE waits for start. CHECK validates the current port. STEP evaluates one slot of an eight-slot write plan and either loads a command or skips the slot. SEND holds the command until it is accepted. The transitions are as follows:
- IDLE goes to CHECK on start.
- CHECK goes to IDLE with an error on a bad configuration, and otherwise to STEP.
- STEP goes to SEND when the slot produces a write.
- After a skipped slot in STEP, or an accepted command in SEND, the machine moves to the next slot (STEP), to the next port (CHECK), or, after the last slot of the last port, to IDLE with done.

Top module: `xmii_clk_seq`

## Requirements
- R1: Every clock-select write has the source code in bits 28:24, bit 11 set, bit 0 as power-down (0 here), and all other bits zero.
- R2: Source codes are as follows. For port p, its own transmit pin is 2p and its own receive pin is 2p+1. PLL0 is 0x0B, PLL1 is 0x0E, and the divider of port p is 0x11+p.
- R3: A divider write has 0x0A in bits 28:24, bit 11 set, (factor−1) in bits 5:2, and bit 0 = 1 when the divider is disabled.
- R4: Interface code 0 (MII) issues four writes, and a PHY-role port (role bit 1) adds two more. The order is:
  1. the divider, enabled only for PHY, with factor 1;
  2. the transmit select: the port's own transmit pin for MAC, or the port's divider for PHY;
  3. the receive select: the port's own receive pin;
  4. for PHY only, the external transmit select and then the external receive select, both set to the port's divider;
  5. the receive-pad write.
- R5: Interface code 2 (RGMII) behaves by speed code. Code 2 (1000 Mb/s) writes a disabled divider and selects PLL0 for transmit. Code 1 (100 Mb/s) writes the divider enabled with factor 1, and code 0 (10 Mb/s) writes it enabled with factor 10; both select the port's divider for transmit. Code 3 (auto) issues only the receive-pad write, with no error.
- R6: Interface code 1 (RMII) issues the following writes in order:
  1. in MAC role, the PLL word 0x0A010941 followed by 0x0A010940;
  2. a disabled divider with factor 1;
  3. the reference select, set to the port's own transmit pin;
  4. in MAC role, the external transmit select, set to PLL1;
  5. the receive pad.
- R7: Interface code 3 (SGMII) issues only the receive-pad write. Every successfully configured port ends with the receive-pad write of parameter word PAD_RX_WORD.
- R8: Register addresses are computed as follows:
  - a per-port register is at BASE_ADDR + kind·KIND_SPAN + port·PORT_STRIDE;
  - the PLL register is at BASE_ADDR + 8·KIND_SPAN;
  - the kind numbers are divider 0, transmit 1, receive 2, external transmit 3, external receive 4, RGMII transmit 5, reference 6, RMII external transmit 7, PLL 8 and receive pad 9.
  
  A write is skipped, and the sequence continues, when bit kind·NPORTS+port of KIND_ABSENT is set or the computed address is all ones.
- R9: An interface code of 4 to 7, or an RGMII port with a speed code of 4 to 7, stops the run before any write for that port. The block then raises err with err_port holding that port, and no further command follows.
- R10: Ports are served in ascending order, and done rises once the last port's writes are accepted. done and err stay until the next accepted start and are never both high.
- R11: While cmd_valid is high and cmd_ready is low, cmd_addr and cmd_data stay unchanged and cmd_valid stays high.
- R12: A start pulse while busy has no effect on the command stream. A synchronous reset returns the block to idle with cmd_valid, busy, done and err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when idle |
| cfg_mode | input | 3·NPORTS | Interface code per port, port p at bits 3p+2:3p |
| cfg_phy | input | NPORTS | Role per port, 1 = PHY, 0 = MAC |
| cfg_speed | input | 3·NPORTS | Speed code per port, port p at bits 3p+2:3p |
| cmd_valid | output | 1 | A write command is offered |
| cmd_ready | input | 1 | The consumer accepts the offered command |
| cmd_addr | output | AW | Target register address |
| cmd_data | output | 32 | Register data word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run finished cleanly |
| err | output | 1 | The last run stopped on a bad port setting |
| err_port | output | PW | Port that caused the error |

## Verification
The bench aims at the corner cases below:
- A PHY-role MII port must get exactly two extra writes. A design that decoded role wrongly would emit four or eight writes and shift the whole remaining stream.
- The RGMII auto speed must yield only the pad write. A design that treated auto as an error would stop the run early.
- An RMII MAC port must write the PLL twice with only bit 0 differing. A design that wrote it once would leave the PLL either parked or never reset.
- Absent registers are placed on an external receive, a reference and a pad slot. A design that stalled on a skip, or sent the all-ones address, would hang or miscompare.
- An unknown code on a middle port must end the stream right after the previous port's pad write.
- Randomly stalled readiness and starts pulsed mid-run expose commands that change before acceptance or runs that restart.

// File: rtl/xclk_pkg.sv
package xclk_pkg;

    localparam int MODE_W = 3;
    localparam int SPD_W  = 3;
    localparam int NSTEP  = 8;
    localparam int STEP_W = 3;
    localparam int NKIND  = 10;

    // interface codes
    localparam logic [MODE_W-1:0] MD_MII   = 3'd0;
    localparam logic [MODE_W-1:0] MD_RMII  = 3'd1;
    localparam logic [MODE_W-1:0] MD_RGMII = 3'd2;
    localparam logic [MODE_W-1:0] MD_SGMII = 3'd3;

    // speed codes
    localparam logic [SPD_W-1:0] SP_10   = 3'd0;
    localparam logic [SPD_W-1:0] SP_100  = 3'd1;
    localparam logic [SPD_W-1:0] SP_1000 = 3'd2;
    localparam logic [SPD_W-1:0] SP_AUTO = 3'd3;

    // source codes
    localparam logic [4:0] SRC_PLL0  = 5'h0B;
    localparam logic [4:0] SRC_PLL1  = 5'h0E;
    localparam logic [4:0] SRC_DIV0  = 5'h11;
    localparam logic [4:0] SRC_DIVIN = 5'h0A;

    typedef enum logic [3:0] {
        K_DIV      = 4'd0,
        K_TX_SEL   = 4'd1,
        K_RX_SEL   = 4'd2,
        K_XTX_SEL  = 4'd3,
        K_XRX_SEL  = 4'd4,
        K_RG_TX    = 4'd5,
        K_REF_SEL  = 4'd6,
        K_RM_XTX   = 4'd7,
        K_PLL      = 4'd8,
        K_PAD_RX   = 4'd9
    } reg_kind_e;

    typedef struct packed {
        logic       active;
        reg_kind_e  kind;
        logic [31:0] data;
    } slot_t;

    function automatic logic [31:0] sel_word(input logic [4:0] src);
        return {3'b000, src, 12'h000, 1'b1, 10'h000, 1'b0};
    endfunction

    function automatic logic [31:0] div_word(input logic en, input logic [3:0] fm1);
        return {3'b000, SRC_DIVIN, 12'h000, 1'b1, 5'h00, fm1, 1'b0, ~en};
    endfunction

    function automatic logic [31:0] pll_word(input logic pdn);
        // src 0x0A, mult 1, auto-block, post-div 1, direct 0, feedback 1, bypass 0
        return {3'b000, SRC_DIVIN, 8'h01, 4'h0, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1,
                4'h0, 1'b0, pdn};
    endfunction

endpackage

// File: rtl/xclk_slot_plan.sv
module xclk_slot_plan
    import xclk_pkg::*;
#(
    parameter int          PW          = 3,
    parameter logic [31:0] PAD_RX_WORD = 32'h0202_0312
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              phy,
    input  logic [SPD_W-1:0]  speed,
    input  logic [PW-1:0]     port,
    input  logic [STEP_W-1:0] step,
    output slot_t             slot
);

    logic [4:0] own_tx;
    logic [4:0] own_rx;
    logic [4:0] own_div;
    logic       rg_slow;

    always_comb begin
        own_tx  = 5'(port) << 1;
        own_rx  = own_tx | 5'd1;
        own_div = SRC_DIV0 + 5'(port);
        rg_slow = (speed == SP_10) || (speed == SP_100);
    end

    always_comb begin
        slot = '0;
        case (step)
            3'd0, 3'd1: begin
                if (mode == MD_RMII && !phy) begin
                    slot.active = 1'b1;
                    slot.kind   = K_PLL;
                    slot.data   = pll_word(step == 3'd0);
                end
            end
            3'd2: begin
                if (mode == MD_MII) begin
                    slot.active = 1'b1;
                    slot.kind   = K_DIV;
                    slot.data   = div_word(phy, 4'd0);
                end else if (mode == MD_RMII) begin
                    slot.active = 1'b1;
                    slot.kind   = K_DIV;
                    slot.data   = div_word(1'b0, 4'd0);
                end else if (mode == MD_RGMII && (rg_slow || speed == SP_1000)) begin
                    slot.active = 1'b1;
                    slot.kind   = K_DIV;
                    slot.data   = div_word(rg_slow, (speed == SP_10) ? 4'd9 : 4'd0);
                end
            end
            3'd3: begin
                if (mode == MD_MII) begin
                    slot.active = 1'b1;
                    slot.kind   = K_TX_SEL;
                    slot.data   = sel_word(phy ? own_div : own_tx);
                end else if (mode == MD_RMII) begin
                    slot.active = 1'b1;
                    slot.kind   = K_REF_SEL;
                    slot.data   = sel_word(own_tx);
                end else if (mode == MD_RGMII && (rg_slow || speed == SP_1000)) begin
                    slot.active = 1'b1;
                    slot.kind   = K_RG_TX;
                    slot.data   = sel_word(rg_slow ? own_div : SRC_PLL0);
                end
            end
            3'd4: begin
                if (mode == MD_MII) begin
                    slot.active = 1'b1;
                    slot.kind   = K_RX_SEL;
                    slot.data   = sel_word(own_rx);
                end else if (mode == MD_RMII && !phy) begin
                    slot.active = 1'b1;
                    slot.kind   = K_RM_XTX;
                    slot.data   = sel_word(SRC_PLL1);
                end
            end
            3'd5: begin
                if (mode == MD_MII && phy) begin
                    slot.active = 1'b1;
                    slot.kind   = K_XTX_SEL;
                    slot.data   = sel_word(own_div);
                end
            end
            3'd6: begin
                if (mode == MD_MII && phy) begin
                    slot.active = 1'b1;
                    slot.kind   = K_XRX_SEL;
                    slot.data   = sel_word(own_div);
                end
            end
            default: begin
                if (mode <= MD_SGMII) begin
                    slot.active = 1'b1;
                    slot.kind   = K_PAD_RX;
                    slot.data   = PAD_RX_WORD;
                end
            end
        endcase
    end

endmodule

// File: rtl/xclk_addr_map.sv
module xclk_addr_map
    import xclk_pkg::*;
#(
    parameter int                  NPORTS      = 5,
    parameter int                  PW          = 3,
    parameter int                  AW          = 32,
    parameter logic [AW-1:0]       BASE_ADDR   = '0,
    parameter logic [AW-1:0]       KIND_SPAN   = '0,
    parameter logic [AW-1:0]       PORT_STRIDE = '0,
    parameter logic [NKIND*NPORTS-1:0] KIND_ABSENT = '0
) (
    input  reg_kind_e      kind,
    input  logic [PW-1:0]  port,
    output logic [AW-1:0]  addr,
    output logic           absent
);

    localparam int MASK_W = NKIND * NPORTS;

    logic [AW-1:0] kind_off;
    logic [AW-1:0] port_off;
    logic [$clog2(MASK_W+1)-1:0] bit_idx;

    always_comb begin
        kind_off = AW'(kind) * KIND_SPAN;
        port_off = (kind == K_PLL) ? '0 : AW'(port) * PORT_STRIDE;
        addr     = BASE_ADDR + kind_off + port_off;
        bit_idx  = ($clog2(MASK_W+1))'(int'(kind) * NPORTS + int'(port));
        absent   = KIND_ABSENT[bit_idx] || (addr == '1);
    end

endmodule

// File: rtl/xmii_clk_seq.sv
module xmii_clk_seq
    import xclk_pkg::*;
#(
    parameter int                  NPORTS      = 5,
    parameter int                  AW          = 32,
    parameter logic [AW-1:0]       BASE_ADDR   = 32'h0010_0000,
    parameter logic [AW-1:0]       KIND_SPAN   = 32'h0000_0040,
    parameter logic [AW-1:0]       PORT_STRIDE = 32'h0000_0004,
    parameter logic [NKIND*NPORTS-1:0] KIND_ABSENT = '0,
    parameter logic [31:0]         PAD_RX_WORD = 32'h0202_0312,
    localparam int                 PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [NPORTS*MODE_W-1:0] cfg_mode,
    input  logic [NPORTS-1:0]        cfg_phy,
    input  logic [NPORTS*SPD_W-1:0]  cfg_speed,
    output logic                     cmd_valid,
    input  logic                     cmd_ready,
    output logic [AW-1:0]            cmd_addr,
    output logic [31:0]              cmd_data,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic [PW-1:0]            err_port
);

    typedef enum logic [1:0] {S_IDLE, S_CHECK, S_STEP, S_SEND} state_e;

    state_e             state, state_nx;
    logic [PW-1:0]      port_q;
    logic [STEP_W-1:0]  step_q;
    reg_kind_e          kind_q;
    logic [AW-1:0]      addr_q;
    logic [31:0]        data_q;
    logic               done_q, err_q;
    logic [PW-1:0]      err_port_q;

    logic [MODE_W-1:0]  mode_sel;
    logic               phy_sel;
    logic [SPD_W-1:0]   speed_sel;
    logic               cfg_bad;
    logic               last_step, last_port, skip, advance;
    slot_t              slot;
    logic [AW-1:0]      slot_addr;
    logic               slot_absent;

    always_comb begin
        mode_sel  = cfg_mode[int'(port_q)*MODE_W +: MODE_W];
        phy_sel   = cfg_phy[port_q];
        speed_sel = cfg_speed[int'(port_q)*SPD_W +: SPD_W];
        cfg_bad   = (mode_sel > MD_SGMII) ||
                    (mode_sel == MD_RGMII && speed_sel > SP_AUTO);
        last_step = (step_q == STEP_W'(NSTEP-1));
        last_port = (port_q == PW'(NPORTS-1));
    end

    xclk_slot_plan #(.PW(PW), .PAD_RX_WORD(PAD_RX_WORD)) u_plan (
        .mode  (mode_sel),
        .phy   (phy_sel),
        .speed (speed_sel),
        .port  (port_q),
        .step  (step_q),
        .slot  (slot)
    );

    xclk_addr_map #(
        .NPORTS(NPORTS), .PW(PW), .AW(AW), .BASE_ADDR(BASE_ADDR),
        .KIND_SPAN(KIND_SPAN), .PORT_STRIDE(PORT_STRIDE), .KIND_ABSENT(KIND_ABSENT)
    ) u_map (
        .kind   (slot.kind),
        .port   (port_q),
        .addr   (slot_addr),
        .absent (slot_absent)
    );

    always_comb begin
        skip    = !slot.active || slot_absent;
        advance = (state == S_STEP && skip) || (state == S_SEND && cmd_ready);
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_CHECK;
            S_CHECK: state_nx = cfg_bad ? S_IDLE : S_STEP;
            S_STEP:  begin
                if (!skip)                       state_nx = S_SEND;
                else if (last_step && last_port) state_nx = S_IDLE;
                else if (last_step)              state_nx = S_CHECK;
            end
            S_SEND:  begin
                if (cmd_ready) begin
                    if (last_step && last_port) state_nx = S_IDLE;
                    else if (last_step)         state_nx = S_CHECK;
                    else                        state_nx = S_STEP;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // datapath and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            port_q     <= '0;
            step_q     <= '0;
            kind_q     <= K_DIV;
            addr_q     <= '0;
            data_q     <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            err_port_q <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                port_q <= '0;
                step_q <= '0;
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (state == S_CHECK) begin
                step_q <= '0;
                if (cfg_bad) begin
                    err_q      <= 1'b1;
                    err_port_q <= port_q;
                end
            end
            if (state == S_STEP && !skip) begin
                kind_q <= slot.kind;
                addr_q <= slot_addr;
                data_q <= slot.data;
            end
            if (advance) begin
                if (last_step) begin
                    step_q <= '0;
                    if (last_port) done_q <= 1'b1;
                    else           port_q <= port_q + 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        cmd_valid = (state == S_SEND);
        cmd_addr  = addr_q;
        cmd_data  = data_q;
        busy      = (state != S_IDLE);
        done      = done_q;
        err       = err_q;
        err_port  = err_port_q;
    end

    AST_AUTO_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind_q != K_PAD_RX) |-> (cmd_data[11] && cmd_data[31:29] == 3'b000)); // R1
    AST_NO_ABSENT_ADDR: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_addr != '1)); // R8
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        err |-> !cmd_valid); // R9
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10
    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data))); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cmd_valid); // R12

endmodule

// File: tb/tb_xmii_clk_seq.sv
`timescale 1ns/1ps
module tb_xmii_clk_seq;

    localparam int NP = 5;
    localparam int AW = 32;
    localparam logic [31:0] BASE   = 32'h0010_0000;
    localparam logic [31:0] SPAN   = 32'h0000_0040;
    localparam logic [31:0] STRIDE = 32'h0000_0004;
    localparam logic [31:0] PADW   = 32'h0202_0312;
    // absent: external receive on port 3, reference on port 1, pad on port 4
    localparam logic [10*NP-1:0] ABS = (50'd1 << (4*NP+3)) | (50'd1 << (6*NP+1)) | (50'd1 << (9*NP+4));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [NP*3-1:0] cfg_mode = '0;
    logic [NP-1:0]   cfg_phy = '0;
    logic [NP*3-1:0] cfg_speed = '0;
    logic cmd_valid, cmd_ready;
    logic [AW-1:0] cmd_addr;
    logic [31:0] cmd_data;
    logic busy, done, err;
    logic [2:0] err_port;

    always #2.5 clk = ~clk;

    xmii_clk_seq #(
        .NPORTS(NP), .AW(AW), .BASE_ADDR(BASE), .KIND_SPAN(SPAN),
        .PORT_STRIDE(STRIDE), .KIND_ABSENT(ABS), .PAD_RX_WORD(PADW)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode), .cfg_phy(cfg_phy),
        .cfg_speed(cfg_speed), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done),
        .err(err), .err_port(err_port)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    int ready_pct = 70;

    logic [31:0] exp_a [0:127];
    logic [31:0] exp_d [0:127];
    int exp_n;
    logic [31:0] got_a [0:127];
    logic [31:0] got_d [0:127];
    int got_n = 0;
    int hold_bad = 0;
    logic prev_stall = 1'b0;
    logic [31:0] prev_a, prev_d;
    logic rdy = 1'b0;
    assign cmd_ready = rdy;

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    // consumer: drive ready, then capture what transfers at the coming edge
    always @(negedge clk) begin
        if (prev_stall && (cmd_addr !== prev_a || cmd_data !== prev_d || !cmd_valid))
            hold_bad++;
        rdy = ($urandom_range(99) < ready_pct);
        #1;
        if (cmd_valid && rdy && !rst) begin
            if (got_n < 128) begin
                got_a[got_n] = cmd_addr;
                got_d[got_n] = cmd_data;
            end
            got_n++;
        end
        prev_stall = cmd_valid && !rdy && !rst;
        prev_a = cmd_addr;
        prev_d = cmd_data;
    end

    // ---- reference model ----
    function automatic logic [31:0] w_sel(input int s);
        return (32'(s) << 24) | 32'h0000_0800;
    endfunction
    function automatic logic [31:0] w_div(input logic en, input int f);
        return 32'h0A00_0800 | (32'(f - 1) << 2) | (en ? 32'd0 : 32'd1);
    endfunction

    task automatic push(input int k, input int p, input logic [31:0] d);
        logic [31:0] a;
        a = BASE + 32'(k) * SPAN + ((k == 8) ? 32'd0 : 32'(p) * STRIDE);
        if (ABS[k*NP+p] || a == 32'hFFFF_FFFF) return;
        exp_a[exp_n] = a;
        exp_d[exp_n] = d;
        exp_n++;
    endtask

    task automatic model(output logic e, output int ep);
        e = 1'b0; ep = 0; exp_n = 0;
        for (int p = 0; p < NP; p++) begin
            int m, s;
            logic ph;
            m = int'(cfg_mode[p*3 +: 3]);
            s = int'(cfg_speed[p*3 +: 3]);
            ph = cfg_phy[p];
            if (m > 3 || (m == 2 && s > 3)) begin
                e = 1'b1; ep = p;
                return;
            end
            if (m == 0) begin
                push(0, p, w_div(ph, 1));
                push(1, p, w_sel(ph ? 17 + p : 2*p));
                push(2, p, w_sel(2*p + 1));
                if (ph) begin
                    push(3, p, w_sel(17 + p));
                    push(4, p, w_sel(17 + p));
                end
            end else if (m == 1) begin
                if (!ph) begin
                    push(8, p, 32'h0A01_0941);
                    push(8, p, 32'h0A01_0940);
                end
                push(0, p, w_div(1'b0, 1));
                push(6, p, w_sel(2*p));
                if (!ph) push(7, p, w_sel(14));
            end else if (m == 2 && s != 3) begin
                if (s == 2) begin
                    push(0, p, w_div(1'b0, 1));
                    push(5, p, w_sel(11));
                end else begin
                    push(0, p, w_div(1'b1, (s == 0) ? 10 : 1));
                    push(5, p, w_sel(17 + p));
                end
            end
            push(9, p, PADW);
        end
    endtask

    task automatic set_port(input int p, input int m, input logic ph, input int s);
        cfg_mode[p*3 +: 3]  = 3'(m);
        cfg_phy[p]          = ph;
        cfg_speed[p*3 +: 3] = 3'(s);
    endtask

    task automatic run_case(input string req, input int poke);
        logic e;
        int ep;
        int first_bad;
        model(e, ep);
        @(negedge clk);
        got_n = 0;
        hold_bad = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (poke > 0 && i == poke) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            #2;
            if (!busy) break;
        end
        #2;
        chk(got_n == exp_n, req, "command count", 32'(got_n), 32'(exp_n));
        first_bad = -1;
        for (int i = 0; i < exp_n && i < got_n; i++)
            if (first_bad < 0 && (got_a[i] !== exp_a[i] || got_d[i] !== exp_d[i])) first_bad = i;
        if (first_bad >= 0)
            chk(1'b0, req, $sformatf("cmd %0d addr/data", first_bad),
                got_d[first_bad], exp_d[first_bad]);
        else
            chk(1'b1, req, "stream", 0, 0);
        chk(done == !e && err == e, req, "done/err", {30'd0, done, err}, {30'd0, !e, e});
        if (e) chk(32'(err_port) == 32'(ep), "R9", "err_port", 32'(err_port), 32'(ep));
        chk(hold_bad == 0, "R11", "command held while stalled", 32'(hold_bad), 0);
    endtask

    initial begin
        void'($urandom(32'd12345));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R12: reset state
        chk(!cmd_valid && !busy && !done && !err, "R12", "reset state",
            {28'd0, cmd_valid, busy, done, err}, 0);

        // R4: MII MAC everywhere, R1/R2 source fields
        for (int p = 0; p < NP; p++) set_port(p, 0, 1'b0, 0);
        run_case("R4 R1 R2 R8 mii-mac", 0);
        // R4: MII PHY (port 3 external receive absent, R8)
        for (int p = 0; p < NP; p++) set_port(p, 0, 1'b1, 0);
        run_case("R4 R3 R8 mii-phy", 0);
        // R6: RMII mixed roles (port 1 reference absent)
        for (int p = 0; p < NP; p++) set_port(p, 1, p[0], 0);
        run_case("R6 R8 rmii", 0);
        // R5 / R7: each RGMII speed and SGMII
        set_port(0, 2, 1'b0, 0);
        set_port(1, 2, 1'b1, 1);
        set_port(2, 2, 1'b0, 2);
        set_port(3, 2, 1'b0, 3);
        set_port(4, 3, 1'b0, 7);
        run_case("R5 R7 R3 rgmii-sgmii", 0);
        // R9: unknown code on port 2
        for (int p = 0; p < NP; p++) set_port(p, 0, 1'b0, 0);
        set_port(2, 5, 1'b0, 0);
        run_case("R9 unknown-mode", 0);
        // R9: illegal RGMII speed on last port
        for (int p = 0; p < NP; p++) set_port(p, 3, 1'b0, 0);
        set_port(4, 2, 1'b0, 6);
        run_case("R9 bad-speed", 0);
        // R12: start while busy ignored
        for (int p = 0; p < NP; p++) set_port(p, 1, 1'b0, 0);
        run_case("R12 R10 start-while-busy", 5);
        // R11: heavy stalls
        ready_pct = 20;
        for (int p = 0; p < NP; p++) set_port(p, 0, 1'b1, 0);
        run_case("R11 R10 stalls", 0);
        ready_pct = 70;

        // random mix
        for (int r = 0; r < 40; r++) begin
            for (int p = 0; p < NP; p++) begin
                int m = ($urandom_range(19) == 0) ? int'($urandom_range(7, 4)) : int'($urandom_range(3));
                int s = ($urandom_range(15) == 0) ? int'($urandom_range(7, 4)) : int'($urandom_range(3));
                set_port(p, m, 1'($urandom_range(1)), s);
            end
            ready_pct = int'($urandom_range(90, 30));
            run_case("R4 R5 R6 R7 R10 random", (r % 4 == 0) ? 3 : 0);
        end

        // R12: reset in the middle of a run
        for (int p = 0; p < NP; p++) set_port(p, 0, 1'b1, 0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!cmd_valid && !busy && !done && !err, "R12", "mid-run reset",
            {28'd0, cmd_valid, busy, done, err}, 0);

        finish_run();
    end

endmodule